// File: doc/BRIEF.md
# Buffer Slot Allocation Controller

This block hands out and takes back slots from a fixed pool of buffer slots. It holds one busy flag per slot and a separate occupancy counter. A client that needs a slot raises an allocation request. In the same cycle the block presents the index of the lowest-numbered slot that is not in use. If every slot is taken, it instead raises a refusal flag. A client that is done with a slot raises a release request together with that slot's index. At the next clock edge the slot returns to the pool.

A request and a release may arrive in the same cycle, and both take effect at that edge. The granted index always comes from the flags as they stood before the edge. A slot being released in the same cycle is therefore not offered until the cycle after. The refusal flag is driven combinationally from the occupancy counter rather than from the flags. The block does not hold the data stored in the slots, and it does not check whether a release is legal.

Top module: `slot_pool_ctrl`

## Requirements
- R1: Reset (asynchronous, active low) clears every busy flag and sets the occupancy count to zero. The first request after reset is granted slot 0 without refusal.
- R2: `nack` is high exactly when `alloc_req` is high and the occupancy count equals `NUM_SLOTS` (default 32). It is low whenever `alloc_req` is low.
- R3: While `alloc_req` is high and `nack` is low, `grant_slot` is the lowest index whose busy flag is clear in the current, pre-edge state.
- R4: An accepted request (`alloc_req` high, `nack` low) marks the granted slot busy at the next edge. That slot is not granted again on later cycles while it stays busy.
- R5: A release (`free_req` high) clears the flag of slot `free_slot` at the next edge. The slot can be granted from the following cycle on.
- R6: At each edge the occupancy count changes by +1 for an accepted request and by -1 for a release. It always equals the number of busy flags.
- R7: When a request and a release arrive in the same cycle, both apply at that edge. The grant ignores the slot being released. At full occupancy the request is refused while the release still takes effect.
- R8: No slot is granted a second time until it has been released.
- R9: The environment releases only slots that are currently busy. The block relies on this and does not check it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Request one free slot this cycle |
| free_req | input | 1 | Release the slot named by `free_slot` this cycle |
| free_slot | input | ADDR_W ($clog2(NUM_SLOTS)) | Index of the slot being released |
| grant_slot | output | ADDR_W | Lowest free slot index, valid when a request is accepted |
| nack | output | 1 | Request refused because the pool is full |

## Verification
The checker treats every release as legal: a release names a slot whose flag is set at that moment. Several properties depend on this, namely the count bookkeeping, the clearing of the flag and the rule against reallocation. The checker also states it as an assertion on the environment. The stimulus keeps to this rule by drawing every release from the bench's own model of the busy slots, never from a raw random index. The directed part pushes the pool to full and back to empty several times, including simultaneous request and release at full occupancy. The random part switches between fill-heavy and drain-heavy phases so that both ends are reached repeatedly.

// File: rtl/slot_pool_pkg.sv
package slot_pool_pkg;

   // How the lowest free slot is located.
   typedef enum int {
      PICK_SCAN    = 0,   // priority scan across the free mask
      PICK_ISOLATE = 1    // isolate lowest set bit, then OR-encode
   } pick_style_e;

endpackage

// File: rtl/slot_pick_lowest.sv
module slot_pick_lowest
   import slot_pool_pkg::*;
#(
   parameter int          NUM_SLOTS = 32,
   parameter int          ADDR_W    = $clog2(NUM_SLOTS),
   parameter pick_style_e STYLE     = PICK_SCAN
) (
   input  logic [NUM_SLOTS-1:0] busy_i,
   output logic [ADDR_W-1:0]    idx_o
);

   logic [NUM_SLOTS-1:0] free_v;
   assign free_v = ~busy_i;

   generate
      if (STYLE == PICK_SCAN) begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
               if (free_v[i]) idx_o = ADDR_W'(i);
            end
         end
      end else begin : g_isolate
         logic [NUM_SLOTS-1:0] low_bit;
         assign low_bit = free_v & (~free_v + {{(NUM_SLOTS-1){1'b0}}, 1'b1});
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
               if (low_bit[i]) idx_o = idx_o | ADDR_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/slot_busy_map.sv
module slot_busy_map #(
   parameter int NUM_SLOTS = 32,
   parameter int ADDR_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_en_i,
   input  logic [ADDR_W-1:0]    clr_idx_i,
   input  logic                 set_en_i,
   input  logic [ADDR_W-1:0]    set_idx_i,
   output logic [NUM_SLOTS-1:0] busy_o
);

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bit
         logic hit_set, hit_clr;
         assign hit_set = set_en_i && (set_idx_i == ADDR_W'(g));
         assign hit_clr = clr_en_i && (clr_idx_i == ADDR_W'(g));

         // clear is applied first, a set in the same cycle overrides it
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       busy_o[g] <= 1'b0;
            else if (hit_set) busy_o[g] <= 1'b1;
            else if (hit_clr) busy_o[g] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/slot_occupancy.sv
module slot_occupancy #(
   parameter int NUM_SLOTS = 32,
   parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o
);

   localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(NUM_SLOTS);

   logic [CNT_W-1:0] count_n;

   always_comb begin
      count_n = count_o;
      if (inc_i && !dec_i)      count_n = count_o + 1'b1;
      else if (dec_i && !inc_i) count_n = count_o - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_o <= '0;
      else        count_o <= count_n;
   end

   assign full_o = (count_o == FULL_VAL);

endmodule

// File: rtl/slot_pool_ctrl.sv
module slot_pool_ctrl
   import slot_pool_pkg::*;
#(
   parameter int          NUM_SLOTS  = 32,
   parameter pick_style_e PICK_STYLE = PICK_SCAN,
   localparam int         ADDR_W     = $clog2(NUM_SLOTS),
   localparam int         CNT_W      = $clog2(NUM_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic              free_req,
   input  logic [ADDR_W-1:0] free_slot,
   output logic [ADDR_W-1:0] grant_slot,
   output logic              nack
);

   initial begin
      assert (NUM_SLOTS >= 2)
         else $error("slot_pool_ctrl: NUM_SLOTS must be at least 2");
      assert (PICK_STYLE == PICK_SCAN || PICK_STYLE == PICK_ISOLATE)
         else $error("slot_pool_ctrl: unknown PICK_STYLE");
   end

   logic [NUM_SLOTS-1:0] busy_q;
   logic [CNT_W-1:0]     count_q;
   logic                 full;
   logic                 accept;

   assign nack   = alloc_req & full;
   assign accept = alloc_req & ~full;

   slot_pick_lowest #(
      .NUM_SLOTS (NUM_SLOTS),
      .ADDR_W    (ADDR_W),
      .STYLE     (PICK_STYLE)
   ) pick_i (
      .busy_i (busy_q),
      .idx_o  (grant_slot)
   );

   slot_busy_map #(
      .NUM_SLOTS (NUM_SLOTS),
      .ADDR_W    (ADDR_W)
   ) map_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_en_i  (free_req),
      .clr_idx_i (free_slot),
      .set_en_i  (accept),
      .set_idx_i (grant_slot),
      .busy_o    (busy_q)
   );

   slot_occupancy #(
      .NUM_SLOTS (NUM_SLOTS),
      .CNT_W     (CNT_W)
   ) occ_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (accept),
      .dec_i   (free_req),
      .count_o (count_q),
      .full_o  (full)
   );

endmodule

// File: rtl/slot_pool_chk.sv
module slot_pool_chk #(
   parameter int NUM_SLOTS = 32,
   parameter int ADDR_W    = $clog2(NUM_SLOTS),
   parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 alloc_req,
   input logic                 free_req,
   input logic [ADDR_W-1:0]    free_slot,
   input logic [ADDR_W-1:0]    grant_slot,
   input logic                 nack,
   input logic [NUM_SLOTS-1:0] busy,
   input logic [CNT_W-1:0]     count
);

   logic took;
   logic any_clear_below;
   assign took = alloc_req && !nack;

   always_comb begin
      any_clear_below = 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (ADDR_W'(i) < grant_slot && !busy[i]) any_clear_below = 1'b1;
      end
   end

   // R2
   nack_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && int'(count) == NUM_SLOTS) |-> nack);

   // R2
   no_spurious_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nack |-> (alloc_req && int'(count) == NUM_SLOTS));

   // R3
   grant_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      took |-> !busy[grant_slot]);

   // R3
   grant_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      took |-> !any_clear_below);

   // R4
   alloc_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> busy[$past(grant_slot)]);

   // R5
   free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_req |=> !busy[$past(free_slot)]);

   // R6
   count_matches_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(busy) == int'(count));

   // R6
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(count) == int'($past(count)) + int'($past(took)) - int'($past(free_req)));

   // R9
   env_legal_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_req |-> busy[free_slot]);

endmodule

bind slot_pool_ctrl slot_pool_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ADDR_W    (ADDR_W),
   .CNT_W     (CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .alloc_req  (alloc_req),
   .free_req   (free_req),
   .free_slot  (free_slot),
   .grant_slot (grant_slot),
   .nack       (nack),
   .busy       (busy_q),
   .count      (count_q)
);

// File: tb/slot_pool_ctrl_tb_top.sv
module slot_pool_ctrl_tb_top;

   localparam int N  = 32;
   localparam int AW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_req = 1'b0;
   logic          free_req = 1'b0;
   logic [AW-1:0] free_slot = '0;
   logic [AW-1:0] grant_slot;
   logic          nack;

   always #10 clk = ~clk;   // 50 MHz

   slot_pool_ctrl #(.NUM_SLOTS(N)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_req  (alloc_req),
      .free_req   (free_req),
      .free_slot  (free_slot),
      .grant_slot (grant_slot),
      .nack       (nack)
   );

   typedef struct {
      bit    a;
      bit    f;
      int    fs;
      bit    enack;
      int    egrant;
      string tag;
   } item_t;

   item_t q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // bench model of the pool
   bit    mbusy [N];
   int    mcount = 0;

   function automatic int lowest_free();
      for (int i = 0; i < N; i++) if (!mbusy[i]) return i;
      return 0;
   endfunction

   // Driver: drives one cycle, pushes the expectation, advances the model.
   task automatic step(input bit a, input bit f, input int fs, input string tag);
      item_t it;
      @(negedge clk);
      alloc_req = a;
      free_req  = f;
      free_slot = AW'(fs);
      it.a = a; it.f = f; it.fs = fs; it.tag = tag;
      it.enack  = a && (mcount == N);
      it.egrant = lowest_free();
      q.push_back(it);
      if (f) begin mbusy[fs] = 1'b0; mcount--; end
      if (a && !it.enack) begin mbusy[it.egrant] = 1'b1; mcount++; end
   endtask

   // Monitor: samples between edges and compares with the queue.
   bit live [N];
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (nack !== it.enack) begin
               n_fail++;
               $display("FAIL %s nack: actual %0b expected %0b", it.tag, nack, it.enack);
            end
            if (it.a && !it.enack) begin
               n_chk++;
               if (int'(grant_slot) != it.egrant) begin
                  n_fail++;
                  $display("FAIL %s grant: actual %0d expected %0d", it.tag, grant_slot, it.egrant);
               end
            end
            if (it.f) live[it.fs] = 1'b0;
            if (it.a && nack === 1'b0) begin
               n_chk++;
               if (live[grant_slot]) begin
                  n_fail++;
                  $display("FAIL R8 reallocation: actual slot %0d still held, expected a released slot", grant_slot);
               end
               live[grant_slot] = 1'b1;
            end
         end
      end
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung run, expected completion");
         summary();
      end
   end

   int pick;

   initial begin
      // R1: state during and right after reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      alloc_req = 1'b1;
      #5;
      n_chk++;
      if (nack !== 1'b0 || grant_slot !== '0) begin
         n_fail++;
         $display("FAIL R1 in reset: actual nack %0b grant %0d expected 0 0", nack, grant_slot);
      end
      alloc_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      step(1, 0, 0, "R1");                                // slot 0
      for (int i = 1; i < N; i++) step(1, 0, 0, "R3/R4"); // fill 1..31
      step(1, 0, 0, "R2");                                // full: refused
      step(0, 0, 0, "R2");                                // no request: no nack
      step(1, 1, 10, "R7");                               // full + release 10
      step(1, 0, 0, "R5");                                // gets 10
      step(0, 1, 3, "R5");
      step(0, 1, 7, "R5");
      step(1, 0, 0, "R3");                                // gets 3
      step(1, 0, 0, "R4");                                // gets 7, not 3
      step(0, 1, 9, "R5");
      step(1, 1, 2, "R7");                                // gets 9, 2 released
      step(1, 0, 0, "R7");                                // gets 2
      step(1, 0, 0, "R2");                                // full again
      for (int i = N - 1; i >= 0; i--) step(0, 1, i, "R6");
      step(1, 0, 0, "R6");                                // empty: slot 0
      step(1, 1, 0, "R7");                                // gets 1, 0 released
      step(1, 0, 0, "R3");                                // gets 0

      // random traffic, alternating fill-heavy and drain-heavy phases
      for (int ph = 0; ph < 40; ph++) begin
         for (int c = 0; c < 100; c++) begin
            bit a, f;
            int fs;
            a = ($urandom_range(99) < ((ph % 2 == 0) ? 85 : 20));
            f = (mcount > 0) && ($urandom_range(99) < ((ph % 2 == 0) ? 20 : 85));
            fs = 0;
            if (f) begin
               pick = $urandom_range(N - 1);
               for (int k = 0; k < N; k++) begin
                  if (mbusy[(pick + k) % N]) begin fs = (pick + k) % N; break; end
               end
            end
            step(a, f, fs, "R2/R3/R8");
         end
      end

      step(0, 0, 0, "R2");
      @(negedge clk);
      @(negedge clk);
      #8;
      done = 1'b1;
      summary();
   end

endmodule